// File: doc/BRIEF.md
# Microprogram Sequencer with Branch Control

This block is the next-address engine of a microprogrammed control unit. A control address register points into a small built-in control store. On every clock the word at that address is captured into a control data register, whose control-signal field drives the block's output. On the same edge, the condition, branch and address fields of that word pick the next control address.

There are five ways to leave a microinstruction. It can step to the following address. It can jump. It can call a subroutine, keeping one return address. It can return. It can dispatch on the current machine opcode. A condition selector qualifies jump and call against the zero, carry or sign flag, or makes them unconditional. Return and dispatch never look at the flags.

The built-in table holds a short test program. Address 0 is the fetch microroutine, and the word after it dispatches on the opcode.

Top module: `useq_top`

## Requirements
- R1: While `rstN` is low the control address is 0, the control output is 0 and the saved return address is cleared.
- R2: One microinstruction per clock. On each rising edge the word at the current control address is latched, and its control field appears on `ctrlOut` in the cycle that follows. On that same edge the control address moves to the next address.
- R3: Branch code 0 steps to the current address plus one, wrapping modulo 2^7. Codes 5 to 7 do the same. A jump or call whose condition is false also steps.
- R4: The condition code selects the qualifying status: 0 always true, 1 `flagZero`, 2 `flagCarry`, 3 `flagSign`. The flags are sampled at the edge on which the decision is taken.
- R5: Branch code 1 (jump) with a true condition loads the word's address field.
- R6: Branch code 2 (call) with a true condition loads the address field and saves the current address plus one in the single return register. No other word changes that register.
- R7: Branch code 3 (return) loads the saved return address whatever the flags.
- R8: Branch code 4 (map) loads {0, opcode[3:0], 00}, that is opcode times 4, whatever the flags.
- R9: Word layout, MSB first: control[7:0], condition[1:0], branch[2:0], address[6:0]. Table entries, written as address: control/condition/branch/target:
  - 0: 11/0/0/0
  - 1: 12/0/4/0
  - 4: 21/1/1/20h
  - 5: 22/0/5/20h
  - 6: 23/0/1/0
  - 8: 31/2/2/30h
  - 9: 32/0/1/0
  - 12: 41/0/2/30h
  - 13: 42/3/2/30h
  - 14: 43/0/1/0
  - 20h: 51/0/1/0
  - 30h: 61/0/0/0
  - 31h: 62/0/3/0
  - Every other address holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| flagZero | input | 1 | Zero status flag |
| flagCarry | input | 1 | Carry status flag |
| flagSign | input | 1 | Sign status flag |
| opcode | input | 4 | Current machine-instruction opcode |
| ctrlOut | output | 8 | Control-signal field of the latched microinstruction |
| ctrlAddr | output | 7 | Current control address |

## Verification
A taken call saves its return address on the same edge that replaces the control address. That register is later read by a return, which may follow the call directly. The two therefore meet whenever a return at 31h lands back on a calling word, as it does at address 13. The bench provokes this by changing the flags and opcode every cycle from a shift-register sequence. It steers opcodes toward the dispatch targets that call. A behavioural model, holding its own return variable, then judges every cycle's address and control field.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  parameter int ADDR_W = 7;
  parameter int CTRL_W = 8;
  parameter int OPC_W  = 4;
  parameter int COND_W = 2;
  parameter int BR_W   = 3;

  localparam logic [COND_W-1:0] CND_ALWAYS = 2'd0;
  localparam logic [COND_W-1:0] CND_ZERO   = 2'd1;
  localparam logic [COND_W-1:0] CND_CARRY  = 2'd2;
  localparam logic [COND_W-1:0] CND_SIGN   = 2'd3;

  localparam logic [BR_W-1:0] BR_NEXT = 3'd0;
  localparam logic [BR_W-1:0] BR_JUMP = 3'd1;
  localparam logic [BR_W-1:0] BR_CALL = 3'd2;
  localparam logic [BR_W-1:0] BR_RET  = 3'd3;
  localparam logic [BR_W-1:0] BR_MAP  = 3'd4;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [COND_W-1:0] cond;
    logic [BR_W-1:0]   br;
    logic [ADDR_W-1:0] addr;
  } uword_t;

  typedef struct packed {
    logic selStep;
    logic selTarget;
    logic selReturn;
    logic selMap;
    logic saveReturn;
  } seqStrobe_t;

  function automatic uword_t mkWord(input logic [CTRL_W-1:0] c, input logic [COND_W-1:0] cd,
                                    input logic [BR_W-1:0] b, input logic [ADDR_W-1:0] a);
    uword_t w;
    w.ctrl = c;
    w.cond = cd;
    w.br   = b;
    w.addr = a;
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] rdAddr,
  output uword_t            rdWord
);
  localparam logic [ADDR_W-1:0] SUB_ADDR  = 7'h30;
  localparam logic [ADDR_W-1:0] ZERO_HIT  = 7'h20;
  localparam logic [ADDR_W-1:0] FETCH     = 7'h00;

  always_comb begin
    unique case (rdAddr)
      7'd0:  rdWord = mkWord(8'h11, CND_ALWAYS, BR_NEXT, FETCH);
      7'd1:  rdWord = mkWord(8'h12, CND_ALWAYS, BR_MAP,  FETCH);
      7'd4:  rdWord = mkWord(8'h21, CND_ZERO,   BR_JUMP, ZERO_HIT);
      7'd5:  rdWord = mkWord(8'h22, CND_ALWAYS, 3'd5,    ZERO_HIT);
      7'd6:  rdWord = mkWord(8'h23, CND_ALWAYS, BR_JUMP, FETCH);
      7'd8:  rdWord = mkWord(8'h31, CND_CARRY,  BR_CALL, SUB_ADDR);
      7'd9:  rdWord = mkWord(8'h32, CND_ALWAYS, BR_JUMP, FETCH);
      7'd12: rdWord = mkWord(8'h41, CND_ALWAYS, BR_CALL, SUB_ADDR);
      7'd13: rdWord = mkWord(8'h42, CND_SIGN,   BR_CALL, SUB_ADDR);
      7'd14: rdWord = mkWord(8'h43, CND_ALWAYS, BR_JUMP, FETCH);
      7'h20: rdWord = mkWord(8'h51, CND_ALWAYS, BR_JUMP, FETCH);
      7'h30: rdWord = mkWord(8'h61, CND_ALWAYS, BR_NEXT, FETCH);
      7'h31: rdWord = mkWord(8'h62, CND_ALWAYS, BR_RET,  FETCH);
      default: rdWord = '0;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
`timescale 1ns/1ps
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [COND_W-1:0] condSel,
  input  logic [BR_W-1:0]   brType,
  input  logic              flagZero,
  input  logic              flagCarry,
  input  logic              flagSign,
  output seqStrobe_t        strobe
);
  logic condTrue;

  always_comb begin
    unique case (condSel)
      CND_ZERO:  condTrue = flagZero;
      CND_CARRY: condTrue = flagCarry;
      CND_SIGN:  condTrue = flagSign;
      default:   condTrue = 1'b1;
    endcase
  end

  always_comb begin
    strobe = '0;
    unique case (brType)
      BR_JUMP: begin
        strobe.selTarget = condTrue;
        strobe.selStep   = !condTrue;
      end
      BR_CALL: begin
        strobe.selTarget  = condTrue;
        strobe.saveReturn = condTrue;
        strobe.selStep    = !condTrue;
      end
      BR_RET:  strobe.selReturn = 1'b1;
      BR_MAP:  strobe.selMap    = 1'b1;
      default: strobe.selStep   = 1'b1;
    endcase
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.selStep, strobe.selTarget, strobe.selReturn, strobe.selMap}) == 1); // R3
  AST_SAVE_WITH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveReturn |-> strobe.selTarget); // R6
endmodule

// File: rtl/useq_path.sv
`timescale 1ns/1ps
module useq_path
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  uword_t            word,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] carQ,
  output logic [CTRL_W-1:0] ctrlOut
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  uword_t            cdrQ;
  logic [ADDR_W-1:0] sbrQ;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] addrField;

  assign addrField = word.addr;

  always_comb begin
    mapAddr = '0;
    mapAddr[OPC_W+1:2] = opcode;
  end

  always_comb begin
    if (strobe.selTarget)      nextAddr = addrField;
    else if (strobe.selReturn) nextAddr = sbrQ;
    else if (strobe.selMap)    nextAddr = mapAddr;
    else                       nextAddr = carQ + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carQ <= '0;
      cdrQ <= '0;
      sbrQ <= '0;
    end else begin
      carQ <= nextAddr;
      cdrQ <= word;
      if (strobe.saveReturn) sbrQ <= carQ + ONE;
    end
  end

  assign ctrlOut = cdrQ.ctrl;

  AST_CDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cdrQ == $past(word)); // R2
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selStep |=> carQ == $past(carQ) + ONE); // R3
  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selTarget |=> carQ == $past(addrField)); // R5
  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveReturn |=> sbrQ == $past(carQ) + ONE); // R6
  AST_SBR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveReturn |=> $stable(sbrQ)); // R6
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selReturn |=> carQ == $past(sbrQ)); // R7
  AST_MAP_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selMap |=> (carQ[1:0] == 2'b00) && (carQ[ADDR_W-1:OPC_W+2] == '0)); // R8
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagZero,
  input  logic              flagCarry,
  input  logic              flagSign,
  input  logic [OPC_W-1:0]  opcode,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic [ADDR_W-1:0] ctrlAddr
);
  uword_t     curWord;
  seqStrobe_t strobe;

  useq_store u_store (
    .rdAddr (ctrlAddr),
    .rdWord (curWord)
  );

  useq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condSel   (curWord.cond),
    .brType    (curWord.br),
    .flagZero  (flagZero),
    .flagCarry (flagCarry),
    .flagSign  (flagSign),
    .strobe    (strobe)
  );

  useq_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .word    (curWord),
    .opcode  (opcode),
    .carQ    (ctrlAddr),
    .ctrlOut (ctrlOut)
  );

  AST_RESET_FETCH: assert property (@(posedge clk)
    !rstN |=> (ctrlAddr == '0) && (ctrlOut == '0)); // R1
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, flagZero, flagCarry, flagSign;
  logic [3:0] opcode;
  logic [7:0] ctrlOut;
  logic [6:0] ctrlAddr;

  useq_top u_dut (
    .clk(clk), .rstN(rstN), .flagZero(flagZero), .flagCarry(flagCarry),
    .flagSign(flagSign), .opcode(opcode), .ctrlOut(ctrlOut), .ctrlAddr(ctrlAddr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // R9 test program, as {control, condition, branch, target}
  function automatic logic [19:0] refWord(input logic [6:0] a);
    case (a)
      7'd0:  return {8'h11, 2'd0, 3'd0, 7'h00};
      7'd1:  return {8'h12, 2'd0, 3'd4, 7'h00};
      7'd4:  return {8'h21, 2'd1, 3'd1, 7'h20};
      7'd5:  return {8'h22, 2'd0, 3'd5, 7'h20};
      7'd6:  return {8'h23, 2'd0, 3'd1, 7'h00};
      7'd8:  return {8'h31, 2'd2, 3'd2, 7'h30};
      7'd9:  return {8'h32, 2'd0, 3'd1, 7'h00};
      7'd12: return {8'h41, 2'd0, 3'd2, 7'h30};
      7'd13: return {8'h42, 2'd3, 3'd2, 7'h30};
      7'd14: return {8'h43, 2'd0, 3'd1, 7'h00};
      7'h20: return {8'h51, 2'd0, 3'd1, 7'h00};
      7'h30: return {8'h61, 2'd0, 3'd0, 7'h00};
      7'h31: return {8'h62, 2'd0, 3'd3, 7'h00};
      default: return 20'h0;
    endcase
  endfunction

  logic [6:0] mCar, mSbr;
  logic [7:0] mCtrl;
  string      mTag;

  always @(posedge clk) begin : model
    logic [19:0] w;
    logic        c;
    if (!rstN) begin
      mCar = 7'd0; mSbr = 7'd0; mCtrl = 8'd0; mTag = "R1";
    end else begin
      w = refWord(mCar);
      mCtrl = w[19:12];
      case (w[11:10]) // R4 condition select
        2'd1:    c = flagZero;
        2'd2:    c = flagCarry;
        2'd3:    c = flagSign;
        default: c = 1'b1;
      endcase
      case (w[9:7])
        3'd1: if (c) begin mCar = w[6:0]; mTag = "R5"; end
              else begin mCar = mCar + 7'd1; mTag = "R3/R4"; end
        3'd2: if (c) begin mSbr = mCar + 7'd1; mCar = w[6:0]; mTag = "R6"; end
              else begin mCar = mCar + 7'd1; mTag = "R3/R4"; end
        3'd3: begin mCar = mSbr; mTag = "R7"; end
        3'd4: begin mCar = {1'b0, opcode, 2'b00}; mTag = "R8"; end
        default: begin mCar = mCar + 7'd1; mTag = "R3"; end
      endcase
    end
  end

  task automatic checkOut();
    total++;
    if (ctrlAddr !== mCar) begin
      bad++;
      $display("FAIL %s address actual=%h expected=%h", mTag, ctrlAddr, mCar);
    end
    total++;
    if (ctrlOut !== mCtrl) begin
      bad++;
      $display("FAIL R2/R9 control actual=%h expected=%h", ctrlOut, mCtrl);
    end
  endtask

  task automatic checkReset();
    total++;
    if (ctrlAddr !== 7'd0 || ctrlOut !== 8'd0) begin
      bad++;
      $display("FAIL R1 reset actual=%h/%h expected=00/00", ctrlAddr, ctrlOut);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    rstN = 1'b0; flagZero = 1'b0; flagCarry = 1'b0; flagSign = 1'b0; opcode = 4'd0;
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      checkOut();
      if (i == 2000) rstN = 1'b0;
      if (i == 2002) checkReset();
      if (i == 2003) rstN = 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      flagZero  = lfsr[0];
      flagCarry = lfsr[3];
      flagSign  = lfsr[6];
      opcode    = lfsr[9] ? {2'b00, lfsr[5:4]} : lfsr[11:8];
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule